// File: doc/BRIEF.md
# Dual Byte Transceiver with Parity Generation and Checking

This block joins two independent byte lanes between an A side and a B side. Each lane has its own controls: a direction input, an active-low output enable and a parity-sense select. When the direction input is high, the A-side byte is copied to the B side and a parity bit is generated for it. When the direction input is low, the B-side byte is copied to the A side, and the parity bit on the lane's parity pin is checked against that byte.

Each bidirectional pin is modelled as three signals: an input, an output and an output enable. The block can then be synthesized and wrapped in pad cells or an on-chip bus mux. The parity pin changes role with the direction. It is driven while transmitting and read while receiving. Data is never inverted. The block is purely combinational. Lane count and byte width are parameters.

Top module: `dual_parity_xcvr`

## Requirements
- R1: With the lane direction input at 1 (transmit) and the lane enabled, the lane's B output equals its A input bit for bit, with no inversion, and the B output enable is 1.
- R2: With the lane direction input at 0 (receive) and the lane enabled, the lane's A output equals its B input bit for bit, with no inversion, and the A output enable is 1.
- R3: With the lane's active-low enable at 1, the A, B and parity output enables of that lane are all 0, and its A, B and parity outputs are 0.
- R4: A side is driven only in receive and B side only in transmit. The two enables of a lane are never 1 together, and a side that is not driven outputs 0.
- R5: Parity select 1 means odd parity: the number of ones across the 8 data bits and the parity bit is odd. Parity select 0 means even parity: that number is even.
- R6: In transmit with the lane enabled, the parity output enable is 1 and the parity output carries the R5 parity bit of the lane's A input. In any other state, the parity output enable is 0.
- R7: In receive with the lane enabled, the error output is 1 exactly when the parity input differs from the R5 parity bit of the lane's B input.
- R8: The error output is 0 in transmit and whenever the lane is disabled, whatever the parity input.
- R9: The two lanes are independent. Each lane's outputs depend only on its own controls and data, which occupy bits [8*k+7:8*k] of the data vectors and bit k of the per-lane vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_tx | input | NUM_LANES | 1 = A to B (transmit), 0 = B to A (receive), per lane |
| en_n | input | NUM_LANES | Active-low output enable, per lane |
| odd_sel | input | NUM_LANES | 1 = odd parity, 0 = even parity, per lane |
| a_in | input | NUM_LANES*BYTE_W | A-side pin values |
| a_out | output | NUM_LANES*BYTE_W | A-side drive values |
| a_oe | output | NUM_LANES | A-side output enable, per lane |
| b_in | input | NUM_LANES*BYTE_W | B-side pin values |
| b_out | output | NUM_LANES*BYTE_W | B-side drive values |
| b_oe | output | NUM_LANES | B-side output enable, per lane |
| par_in | input | NUM_LANES | Parity pin value seen in receive |
| par_out | output | NUM_LANES | Generated parity bit in transmit |
| par_oe | output | NUM_LANES | Parity pin output enable |
| par_err | output | NUM_LANES | Parity mismatch flag in receive |

## Verification
The bench builds the block with its defaults: two lanes of eight bits. At that size it can sweep every byte value under all eight combinations of direction, enable and parity sense, with both parity input values. Every generated bit and every error flag is checked against a ones count made in the bench. The second lane gets inverted data and a different control pattern in each step. A cross-coupled lane would therefore show up at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_LANES  = 2;

  typedef enum logic {
    FLOW_B_TO_A = 1'b0,
    FLOW_A_TO_B = 1'b1
  } flow_e;
endpackage

// File: rtl/parity_bit.sv
module parity_bit #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         odd_sel,
  output logic         pbit
);
  // even sense: bit equals xor of data; odd sense flips it
  assign pbit = (^data) ^ odd_sel;

  always_comb begin
    if (!$isunknown({data, odd_sel}))
      p_total_sense_r5: assert ((^{data, pbit}) == odd_sel)
        else $error("parity sense violated");
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic              dir_tx,
  input  logic              en_n,
  input  logic              odd_sel,
  input  logic [BYTE_W-1:0] a_in,
  output logic [BYTE_W-1:0] a_out,
  output logic              a_oe,
  input  logic [BYTE_W-1:0] b_in,
  output logic [BYTE_W-1:0] b_out,
  output logic              b_oe,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  output logic              par_err
);
  flow_e       flow;
  logic        live;
  logic        gen_bit;
  logic        chk_bit;

  assign flow = flow_e'(dir_tx);
  assign live = ~en_n;

  parity_bit #(.W(BYTE_W)) u_gen (
    .data    (a_in),
    .odd_sel (odd_sel),
    .pbit    (gen_bit)
  );

  parity_bit #(.W(BYTE_W)) u_chk (
    .data    (b_in),
    .odd_sel (odd_sel),
    .pbit    (chk_bit)
  );

  always_comb begin
    a_oe    = 1'b0;
    b_oe    = 1'b0;
    par_oe  = 1'b0;
    a_out   = '0;
    b_out   = '0;
    par_out = 1'b0;
    par_err = 1'b0;
    if (live) begin
      unique case (flow)
        FLOW_A_TO_B: begin
          b_oe    = 1'b1;
          b_out   = a_in;
          par_oe  = 1'b1;
          par_out = gen_bit;
        end
        FLOW_B_TO_A: begin
          a_oe    = 1'b1;
          a_out   = b_in;
          par_err = par_in ^ chk_bit;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({dir_tx, en_n, odd_sel, a_in, b_in, par_in})) begin
      p_one_side_r4: assert (!(a_oe && b_oe))
        else $error("both sides driven");
      p_quiet_when_off_r3: assert (!en_n || !(a_oe || b_oe || par_oe))
        else $error("drive while disabled");
      p_par_with_b_r6: assert (par_oe == b_oe)
        else $error("parity pin role mismatch");
      p_sent_word_sense_r5: assert (!par_oe || ((^{b_out, par_out}) == odd_sel))
        else $error("sent word has wrong parity");
      p_err_only_rx_r8: assert (!par_err || a_oe)
        else $error("error flag outside receive");
      p_undriven_zero_r4: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0))
        else $error("undriven side not zero");
    end
  end
endmodule

// File: rtl/dual_parity_xcvr.sv
module dual_parity_xcvr
  import xcvr_pkg::*;
#(
  parameter int BYTE_W    = DEF_BYTE_W,
  parameter int NUM_LANES = DEF_LANES
) (
  input  logic [NUM_LANES-1:0]        dir_tx,
  input  logic [NUM_LANES-1:0]        en_n,
  input  logic [NUM_LANES-1:0]        odd_sel,
  input  logic [NUM_LANES*BYTE_W-1:0] a_in,
  output logic [NUM_LANES*BYTE_W-1:0] a_out,
  output logic [NUM_LANES-1:0]        a_oe,
  input  logic [NUM_LANES*BYTE_W-1:0] b_in,
  output logic [NUM_LANES*BYTE_W-1:0] b_out,
  output logic [NUM_LANES-1:0]        b_oe,
  input  logic [NUM_LANES-1:0]        par_in,
  output logic [NUM_LANES-1:0]        par_out,
  output logic [NUM_LANES-1:0]        par_oe,
  output logic [NUM_LANES-1:0]        par_err
);
  localparam int BUS_W = NUM_LANES * BYTE_W;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    xcvr_lane #(.BYTE_W(BYTE_W)) u_lane (
      .dir_tx  (dir_tx[k]),
      .en_n    (en_n[k]),
      .odd_sel (odd_sel[k]),
      .a_in    (a_in[k*BYTE_W +: BYTE_W]),
      .a_out   (a_out[k*BYTE_W +: BYTE_W]),
      .a_oe    (a_oe[k]),
      .b_in    (b_in[k*BYTE_W +: BYTE_W]),
      .b_out   (b_out[k*BYTE_W +: BYTE_W]),
      .b_oe    (b_oe[k]),
      .par_in  (par_in[k]),
      .par_out (par_out[k]),
      .par_oe  (par_oe[k]),
      .par_err (par_err[k])
    );
  end

  always_comb begin
    if (!$isunknown({dir_tx, en_n}))
      p_lane_enables_r9: assert ((a_oe | b_oe) == ~en_n)
        else $error("lane enable map broken, bus width %0d", BUS_W);
  end
endmodule

// File: tb/dual_parity_xcvr_test.sv
module dual_parity_xcvr_test;
  localparam int W  = 8;
  localparam int NL = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NL-1:0]   dir_tx, en_n, odd_sel, par_in;
  logic [NL*W-1:0] a_in, b_in;
  logic [NL*W-1:0] a_out, b_out;
  logic [NL-1:0]   a_oe, b_oe, par_out, par_oe, par_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  dual_parity_xcvr #(.BYTE_W(W), .NUM_LANES(NL)) uut (
    .dir_tx(dir_tx), .en_n(en_n), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .par_err(par_err)
  );

  function automatic logic ones_par(input logic [W-1:0] d, input logic odd);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(d[i]);
    // odd sense: bit makes total odd
    return odd ? ((c % 2) == 0) : ((c % 2) == 1);
  endfunction

  task automatic chk(input string req, input int lane, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s lane %0d: actual=%0h expected=%0h", req, lane, act, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < NL; k++) begin
      logic tx, on, od;
      logic [W-1:0] ea, eb, ai, bi;
      tx = dir_tx[k]; on = ~en_n[k]; od = odd_sel[k];
      ai = a_in[k*W +: W]; bi = b_in[k*W +: W];
      ea = (on && !tx) ? bi : '0;
      eb = (on && tx)  ? ai : '0;
      if (!on) begin
        chk("R3", k, {a_oe[k], b_oe[k], par_oe[k]}, 0);
        chk("R3", k, {a_out[k*W +: W], b_out[k*W +: W], par_out[k]}, 0);
        chk("R8", k, par_err[k], 0);
      end else if (tx) begin
        chk("R1", k, {b_oe[k], b_out[k*W +: W]}, {1'b1, eb});
        chk("R4", k, {a_oe[k], a_out[k*W +: W]}, {1'b0, ea});
        chk("R6", k, {par_oe[k], par_out[k]}, {1'b1, ones_par(ai, od)});
        chk("R8", k, par_err[k], 0);
      end else begin
        chk("R2", k, {a_oe[k], a_out[k*W +: W]}, {1'b1, ea});
        chk("R4", k, {b_oe[k], b_out[k*W +: W]}, {1'b0, eb});
        chk("R6", k, par_oe[k], 0);
        chk("R7", k, par_err[k], par_in[k] != ones_par(bi, od));
      end
    end
  endtask

  initial begin
    // Reset state: both lanes disabled
    dir_tx = '0; en_n = '1; odd_sel = '0; par_in = '0; a_in = '0; b_in = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R3", 0, {a_oe, b_oe, par_oe, par_err}, 0);

    // R5 spot checks with known values
    en_n = 2'b00; dir_tx = 2'b11; odd_sel = 2'b01;
    a_in = {8'h00, 8'h00};
    #1;
    chk("R5", 0, par_out[0], 1);
    chk("R5", 1, par_out[1], 0);
    a_in = {8'h07, 8'h07};
    #1;
    chk("R5", 0, par_out[0], 0);
    chk("R5", 1, par_out[1], 1);

    // Exhaustive sweep; lane 1 gets inverted data and shuffled controls (R9)
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int d = 0; d < 256; d++) begin
        for (int p = 0; p < 2; p++) begin
          @(negedge clk);
          dir_tx  = {1'(((ctl ^ 5) >> 0) & 1), 1'(ctl & 1)};
          en_n    = {1'(((ctl ^ 5) >> 1) & 1), 1'((ctl >> 1) & 1)};
          odd_sel = {1'(((ctl ^ 5) >> 2) & 1), 1'((ctl >> 2) & 1)};
          a_in    = {~8'(d), 8'(d)};
          b_in    = {8'(d * 37 + 11), 8'(d ^ 8'h5A)};
          par_in  = {1'(p ^ 1), 1'(p)};
          #1;
          check_all();
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule